// File: doc/BRIEF.md
# SPI Byte-Memory Slave Engine

This block is an SPI slave that fronts a byte-wide on-chip memory. A system clock samples the four serial pins: chip select, serial clock, serial input and hold. Each chip-select window carries one command byte. Some commands also carry a two-byte address and any number of data bytes. Reads and writes complete at the pace of the serial clock, so the host never has to poll for a ready condition. An address counter steps after every full data byte, which lets one window stream through consecutive locations. The serial output comes with a separate enable so that the pad can be tri-stated.

The engine keeps a write-enable flag and three protection configuration bits. It does not decide on its own whether a given write is allowed. It exposes its current address and the configuration bits, and it accepts two permit inputs from a separate write-protect block.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, `miso_oe` is 0, `prot_cfg` is 0, and a status read returns 0x00.
- R2: Opcode 0x06 sets the write-enable flag and opcode 0x04 clears it. Opcode 0x05 shifts out the status byte, repeated for as long as the clock runs. In the status byte, bit 1 is the write-enable flag, bits 7, 3 and 2 are `prot_cfg[2:0]`, and all other bits are 0.
- R3: Opcode 0x02 is followed by two address bytes and then data bytes. Each data byte is stored only when the write-enable flag is 1 and `wr_permit` is 1. Otherwise the memory is left unchanged.
- R4: Opcode 0x03 is followed by two address bytes. Data then comes out MSB first, with the first bit valid before the first rising clock edge after the address. The output changes only after falling edges. The address advances by one after each full byte, and `cur_addr` shows the next location.
- R5: Only the low AW bits of the 16-bit address field are used; the upper bits are ignored. The address counter wraps from 2^AW-1 to 0.
- R6: When chip select rises at the end of a window whose command was 0x02 or 0x01, the write-enable flag is cleared.
- R7: Opcode 0x01 takes one byte. If the write-enable flag and `sr_permit` are both 1, bits 7, 3 and 2 of that byte are loaded into `prot_cfg[2:0]`. The write-enable flag cannot be written this way.
- R8: Only the first byte of a window is decoded as a command. A byte with no assigned meaning causes the rest of the window to be ignored.
- R9: A write data byte that is cut short by chip select rising is discarded.
- R10: `miso_oe` is 1 only while read data is being shifted out, with chip select low and hold high.
- R11: While `hold_n` is 0, serial clock and chip-select changes are ignored and `miso_oe` is 0. The transfer resumes where it stopped once `hold_n` returns to 1.
- R12: The block works the same whether the serial clock idles low (mode 0) or high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it samples all serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data into the block |
| hold_n | input | 1 | Pause input, active low |
| wr_permit | input | 1 | Write-protect block allows a memory write at `cur_addr` |
| sr_permit | input | 1 | Write-protect block allows a status write |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output enable for the `miso` pad |
| cur_addr | output | AW | Current byte address |
| prot_cfg | output | 3 | Protection configuration bits |

## Verification
The bench builds the block with AW=8, which gives 256 bytes. At that size, the wrap from 0xFF to 0x00 and the ignored upper address byte can both be reached in a few short transfers. The serial clock runs at sixteen system cycles per bit. Hold pauses are placed inside a write byte and inside a read byte. Both clock idle levels are exercised.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_IGN  = 2'd3
  } phase_t;
endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spimem_ram.sv
module spimem_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spimem_pkg::*;
#(
  parameter int AW = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          mosi,
  input  logic          hold_n,
  input  logic          wr_permit,
  input  logic          sr_permit,
  output logic          miso,
  output logic          miso_oe,
  output logic [AW-1:0] cur_addr,
  output logic [2:0]    prot_cfg
);
  localparam int ADDR_BITS = 16;
  localparam logic [3:0] LAST_BIT  = 4'd7;
  localparam logic [3:0] LAST_ABIT = 4'(ADDR_BITS - 1);

  logic [3:0] pins_s;
  logic cs_s, sck_s, mosi_s, hold_s;

  spimem_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst(rst),
    .d({cs_n, sck, mosi, hold_n}),
    .q(pins_s)
  );
  assign {cs_s, sck_s, mosi_s, hold_s} = pins_s;

  logic          cs_act, sck_d, wel, load_next, drive;
  phase_t        phase;
  logic [3:0]    cnt;
  logic [7:0]    ish, osh, cmd;
  logic [AW-1:0] addr;
  logic [2:0]    cfg;
  logic          mem_we;
  logic [AW-1:0] mem_wa;
  logic [7:0]    mem_wd, rdata;

  spimem_ram #(.AW(AW), .DW(8)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
    .raddr(addr), .rdata(rdata)
  );

  logic [7:0] byte_in, status, src;
  logic       rise, fall;

  assign byte_in = {ish[6:0], mosi_s};
  assign status  = {cfg[2], 3'b000, cfg[1], cfg[0], wel, 1'b0};
  assign src     = (cmd == OP_RDSR) ? status : rdata;
  assign rise    = cs_act & hold_s & sck_s & ~sck_d;
  assign fall    = cs_act & hold_s & ~sck_s & sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_act    <= 1'b0;
      sck_d     <= 1'b0;
      wel       <= 1'b0;
      load_next <= 1'b0;
      drive     <= 1'b0;
      phase     <= PH_CMD;
      cnt       <= '0;
      ish       <= '0;
      osh       <= '0;
      cmd       <= '0;
      addr      <= '0;
      cfg       <= '0;
      mem_we    <= 1'b0;
      mem_wa    <= '0;
      mem_wd    <= '0;
      miso      <= 1'b0;
      miso_oe   <= 1'b0;
    end else begin
      sck_d   <= sck_s;
      mem_we  <= 1'b0;
      miso_oe <= drive & cs_act & hold_s;
      if (hold_s) cs_act <= ~cs_s;

      if (!cs_act) begin
        phase     <= PH_CMD;
        cnt       <= '0;
        drive     <= 1'b0;
        load_next <= 1'b0;
        cmd       <= '0;
      end else if (hold_s && cs_s) begin
        if (cmd == OP_WRITE || cmd == OP_WRSR) wel <= 1'b0;
      end else if (rise) begin
        unique case (phase)
          PH_CMD: begin
            ish <= byte_in;
            cnt <= cnt + 4'd1;
            if (cnt == LAST_BIT) begin
              cnt <= '0;
              cmd <= byte_in;
              case (byte_in)
                OP_WREN:  begin wel <= 1'b1; phase <= PH_IGN; end
                OP_WRDI:  begin wel <= 1'b0; phase <= PH_IGN; end
                OP_RDSR:  begin phase <= PH_DATA; load_next <= 1'b1; end
                OP_WRSR:  phase <= PH_DATA;
                OP_READ,
                OP_WRITE: phase <= PH_ADDR;
                default:  phase <= PH_IGN;
              endcase
            end
          end
          PH_ADDR: begin
            addr <= {addr[AW-2:0], mosi_s};
            cnt  <= cnt + 4'd1;
            if (cnt == LAST_ABIT) begin
              cnt       <= '0;
              phase     <= PH_DATA;
              load_next <= (cmd == OP_READ);
            end
          end
          PH_DATA: begin
            ish <= byte_in;
            cnt <= cnt + 4'd1;
            if (cnt == LAST_BIT) begin
              cnt <= '0;
              case (cmd)
                OP_WRITE: begin
                  if (wel && wr_permit) begin
                    mem_we <= 1'b1;
                    mem_wa <= addr;
                    mem_wd <= byte_in;
                  end
                  addr <= addr + AW'(1);
                end
                OP_READ: begin
                  addr      <= addr + AW'(1);
                  load_next <= 1'b1;
                end
                OP_RDSR: load_next <= 1'b1;
                OP_WRSR: begin
                  if (wel && sr_permit) cfg <= {byte_in[7], byte_in[3], byte_in[2]};
                  phase <= PH_IGN;
                end
                default: phase <= PH_IGN;
              endcase
            end
          end
          default: ;
        endcase
      end else if (fall) begin
        if (load_next) begin
          miso      <= src[7];
          osh       <= {src[6:0], 1'b0};
          load_next <= 1'b0;
          drive     <= 1'b1;
        end else if (drive) begin
          miso <= osh[7];
          osh  <= {osh[6:0], 1'b0};
        end
      end
    end
  end

  assign cur_addr = addr;
  assign prot_cfg = cfg;
endmodule

// File: rtl/spimem_chk.sv
module spimem_chk
  import spimem_pkg::*;
#(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_act,
  input logic          hold_s,
  input logic          miso_oe,
  input logic          wel,
  input logic          mem_we,
  input logic [7:0]    cmd,
  input logic [3:0]    cnt,
  input logic [1:0]    phase,
  input logic [AW-1:0] addr
);
  // R10: deselected engine never drives the pad on the next cycle
  a_r10_oe_off_when_idle: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !miso_oe);

  // R11: hold freezes bit position and select state
  a_r11_hold_freeze: assert property (@(posedge clk) disable iff (rst)
    !hold_s |=> ($stable(cnt) && $stable(cs_act)));

  // R11: no output drive while held
  a_r11_hold_no_drive: assert property (@(posedge clk) disable iff (rst)
    !hold_s |=> !miso_oe);

  // R3: memory write strobe only with the enable flag set
  a_r3_we_needs_wel: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wel);

  // R6: leaving a write-type window drops the enable flag
  a_r6_wel_clear: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_act) && ($past(cmd) == OP_WRITE || $past(cmd) == OP_WRSR)) |-> !wel);

  // R4, R5: within a data phase the address only steps by one (mod 2^AW)
  a_r5_addr_step: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA && $past(phase) == PH_DATA && !$stable(addr))
      |-> addr == $past(addr) + AW'(1));
endmodule

bind spi_mem_slave spimem_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .hold_s(hold_s),
  .miso_oe(miso_oe), .wel(wel), .mem_we(mem_we), .cmd(cmd),
  .cnt(cnt), .phase(phase), .addr(addr)
);

// File: tb/tb_spi_mem_slave.sv
module tb_spi_mem_slave;
  localparam int AW = 8;
  localparam int H  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
  logic wr_permit = 1'b1, sr_permit = 1'b1;
  logic miso, miso_oe;
  logic [AW-1:0] cur_addr;
  logic [2:0] prot_cfg;

  spi_mem_slave #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .hold_n(hold_n), .wr_permit(wr_permit), .sr_permit(sr_permit),
    .miso(miso), .miso_oe(miso_oe), .cur_addr(cur_addr), .prot_cfg(prot_cfg)
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit mode3 = 1'b0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares read bytes against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        automatic logic [7:0] g = got_q.pop_front();
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check_eq(t, {24'd0, g}, {24'd0, e});
      end
    end
  end

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_begin();
    sck = mode3;
    wait_h();
    cs_n = 1'b0;
    wait_h();
  endtask

  task automatic cs_end();
    if (!mode3) begin
      sck = 1'b0;
      wait_h();
    end
    cs_n = 1'b1;
    wait_h();
    wait_h();
  endtask

  // sends the top nbits of tx; optionally captures a read byte; optional hold pause
  task automatic xfer(input logic [7:0] tx, input int nbits, input bit cap,
                      input logic [7:0] exp, input string tag, input int hold_at);
    logic [7:0] rx = '0;
    if (cap) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    for (int i = 7; i > 7 - nbits; i--) begin
      sck = 1'b0;
      mosi = tx[i];
      wait_h();
      if (i == hold_at) begin
        hold_n = 1'b0;
        wait_h();
        for (int k = 0; k < 3; k++) begin
          mosi = ~mosi;
          sck = 1'b1; wait_h();
          sck = 1'b0; wait_h();
        end
        check_eq({tag, " R11 oe during hold"}, {31'd0, miso_oe}, 32'd0);
        mosi = tx[i];
        hold_n = 1'b1;
        wait_h();
      end
      if (cap) begin
        rx[i] = miso;
        if (i == 7) check_eq({tag, " R10 oe while reading"}, {31'd0, miso_oe}, 32'd1);
      end
      sck = 1'b1;
      wait_h();
    end
    if (cap) got_q.push_back(rx);
  endtask

  task automatic send(input logic [7:0] b);
    xfer(b, 8, 1'b0, 8'h00, "", -1);
  endtask

  task automatic simple_cmd(input logic [7:0] op);
    cs_begin(); send(op); cs_end();
  endtask

  task automatic rd_status(input logic [7:0] exp, input string tag);
    cs_begin(); send(8'h05); xfer(8'h00, 8, 1'b1, exp, tag, -1); cs_end();
  endtask

  task automatic wr_byte(input logic [15:0] a, input logic [7:0] d);
    simple_cmd(8'h06);
    cs_begin(); send(8'h02); send(a[15:8]); send(a[7:0]); send(d); cs_end();
  endtask

  task automatic rd_bytes(input logic [15:0] a, input logic [7:0] e0, input logic [7:0] e1,
                          input int n, input string tag);
    cs_begin(); send(8'h03); send(a[15:8]); send(a[7:0]);
    xfer(8'h00, 8, 1'b1, e0, tag, -1);
    if (n > 1) xfer(8'h00, 8, 1'b1, e1, tag, -1);
    cs_end();
    check_eq({tag, " R10 oe after window"}, {31'd0, miso_oe}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check_eq("R1 oe after reset", {31'd0, miso_oe}, 32'd0);
    check_eq("R1 cfg after reset", {29'd0, prot_cfg}, 32'd0);
    rd_status(8'h00, "R1 status after reset");

    simple_cmd(8'h06);
    rd_status(8'h02, "R2 WEL set");
    simple_cmd(8'h04);
    rd_status(8'h00, "R2 WEL cleared");

    // multi-byte write
    simple_cmd(8'h06);
    cs_begin(); send(8'h02); send(8'h00); send(8'h10);
    send(8'hA5); send(8'h3C); send(8'hC3); cs_end();
    check_eq("R4 cur_addr after burst", {24'd0, cur_addr}, 32'h13);
    rd_status(8'h00, "R6 WEL cleared after write");
    cs_begin(); send(8'h02); send(8'h00); send(8'h10); send(8'h55); cs_end();
    rd_bytes(16'h0010, 8'hA5, 8'h3C, 2, "R3 R4 burst read");
    rd_bytes(16'h0012, 8'hC3, 8'h00, 1, "R4 third byte");

    // permit from protect block
    wr_byte(16'h0020, 8'h77);
    wr_permit = 1'b0;
    wr_byte(16'h0020, 8'h11);
    wr_permit = 1'b1;
    rd_bytes(16'h0020, 8'h77, 8'h00, 1, "R3 blocked by permit");

    // wrap and ignored upper address bits
    simple_cmd(8'h06);
    cs_begin(); send(8'h02); send(8'hAB); send(8'hFE);
    send(8'h01); send(8'h02); send(8'h03); cs_end();
    check_eq("R5 cur_addr wrapped", {24'd0, cur_addr}, 32'h01);
    rd_bytes(16'h00FF, 8'h02, 8'h03, 2, "R5 wrap read");
    rd_bytes(16'h7FFE, 8'h01, 8'h00, 1, "R5 upper bits ignored");

    // status write
    simple_cmd(8'h06);
    cs_begin(); send(8'h01); send(8'hFF); cs_end();
    check_eq("R7 cfg loaded", {29'd0, prot_cfg}, 32'h7);
    rd_status(8'h8C, "R7 R6 status after WRSR");
    cs_begin(); send(8'h01); send(8'h00); cs_end();
    check_eq("R7 cfg kept without WEL", {29'd0, prot_cfg}, 32'h7);
    sr_permit = 1'b0;
    simple_cmd(8'h06);
    cs_begin(); send(8'h01); send(8'h00); cs_end();
    sr_permit = 1'b1;
    check_eq("R7 cfg kept without permit", {29'd0, prot_cfg}, 32'h7);
    simple_cmd(8'h06);
    cs_begin(); send(8'h01); send(8'h02); cs_end();
    rd_status(8'h00, "R7 WEL not writable");

    // one command per window
    cs_begin(); send(8'hFF); send(8'h06); cs_end();
    rd_status(8'h00, "R8 unknown opcode ignores rest");
    cs_begin(); send(8'h04); send(8'h06); cs_end();
    rd_status(8'h00, "R8 second opcode ignored");
    cs_begin(); send(8'h06); send(8'h04); cs_end();
    rd_status(8'h02, "R8 trailing byte ignored");
    simple_cmd(8'h04);

    // partial byte
    wr_byte(16'h0031, 8'h99);
    simple_cmd(8'h06);
    cs_begin(); send(8'h02); send(8'h00); send(8'h30); send(8'h5A);
    xfer(8'h0F, 4, 1'b0, 8'h00, "", -1);
    cs_end();
    rd_bytes(16'h0030, 8'h5A, 8'h99, 2, "R9 partial byte discarded");

    // hold
    simple_cmd(8'h06);
    cs_begin(); send(8'h02); send(8'h00); send(8'h40);
    xfer(8'h6B, 8, 1'b0, 8'h00, "R11 write", 4);
    cs_end();
    cs_begin(); send(8'h03); send(8'h00); send(8'h40);
    xfer(8'h00, 8, 1'b1, 8'h6B, "R11 read across hold", 3);
    cs_end();

    // mode 3
    mode3 = 1'b1;
    sck = 1'b1;
    wait_h();
    wr_byte(16'h0050, 8'hE7);
    rd_bytes(16'h0050, 8'hE7, 8'h00, 1, "R12 mode 3 round trip");
    rd_status(8'h00, "R12 mode 3 status");

    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule